// File: doc/BRIEF.md
# Video Data-Enable Recovery from Sync

This block sits between a parallel RGB video source and a TMDS encoder. The source delivers a pixel clock, a horizontal sync, a vertical sync and 24 bits of colour, but it does not provide a data-enable. The encoder needs that enable to choose between video data and control symbols. The block rebuilds the enable from the sync edges and the porch and active lengths set in its parameters. It presents the enable together with the sync pair and the colour bytes, all delayed by the same single register stage.

The block measures every line and every frame. It asserts its lock flag only after two consecutive complete frames have each shown the expected number of clocks per line and lines per frame. The enable can only go high while lock is held. A line or frame of the wrong length drops lock at once, and the two-frame qualification starts again. The current pixel and line coordinates are output as well, so the downstream logic can place overlays or check the picture.

The default timing is 1280x720 at 60 Hz with active-high syncs:

| Axis | Sync | Back porch | Active | Front porch | Total |
|------|------|------------|--------|-------------|-------|
| Horizontal (clocks) | 40 | 220 | 1280 | 110 | 1650 |
| Vertical (lines) | 5 | 20 | 720 | 5 | 750 |

The pixel clock is nominally 74.25 MHz. Every length is a parameter, so other modes can be set.

Top module: `dpi_de_recover`

## Requirements
- R1: While `rst_ni` is low, `de_o`, `lock_o`, both sync outputs, the colour outputs and both coordinates are 0. Reset also restarts the two-frame qualification.
- R2: `hsync_o`, `vsync_o`, `red_o`, `green_o` and `blue_o` each equal the matching input from the previous clock, which is the same delay as `de_o`.
- R3: `px_x_o` is 0 for the sample taken on a rising edge of hsync, and it rises by one on each later clock. `px_y_o` is 0 for the line whose hsync rising edge coincides with, or first follows, a vsync rising edge, and it rises by one on each later hsync rising edge. Both are registered with the same delay as `de_o`.
- R4: `de_o` is 1 for a sample exactly when lock was held before that sample, the sample carries no timing fault, `px_x_o` lies in [H_SYNC+H_BACK, H_SYNC+H_BACK+H_ACTIVE) and `px_y_o` lies in [V_SYNC+V_BACK, V_SYNC+V_BACK+V_ACTIVE). With the default timing these ranges are 260..1539 and 25..744.
- R5: After reset, with well-formed input, `lock_o` rises on the third frame start (vsync-aligned hsync rising edge). This is after two complete frames have been measured. The first frame start only opens the first measurement.
- R6: An hsync rising edge that arrives after fewer than H_TOTAL clocks since the previous one clears `lock_o` at that sample.
- R7: If H_TOTAL clocks pass after an hsync rising edge with no new rising edge, `lock_o` is cleared at the sample where the position reaches H_TOTAL.
- R8: If a frame start arrives after a line count different from V_TOTAL, `lock_o` is cleared at that frame start. It is also cleared when a line beyond V_TOTAL begins without a vsync edge.
- R9: After a faulty frame, `lock_o` returns at the third frame start that follows the fault, once two consecutive well-formed frames have been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| red_i | input | CW (8) | Red component |
| green_i | input | CW (8) | Green component |
| blue_i | input | CW (8) | Blue component |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| red_o | output | CW (8) | Delayed red |
| green_o | output | CW (8) | Delayed green |
| blue_o | output | CW (8) | Delayed blue |
| de_o | output | 1 | Recovered video data-enable |
| lock_o | output | 1 | Timing qualified over two frames |
| px_x_o | output | XW (11) | Pixel position within the line |
| px_y_o | output | YW (10) | Line position within the frame |

## Verification
The frame-start decision and the line-length check happen on the same sample. The hsync rising edge that opens line 0 also closes the last line of the previous frame. So one clock must weigh the line count of the old frame, the length of its last line and the increment of the good-frame count. The bench provokes this with a frame that is one line short, and separately with frames that follow a too-short line and a too-long line. It judges the result through `lock_o` on the frame-start sample and on the two later frame starts: lock must stay low until exactly the third frame start after the fault.

// File: rtl/dpi_de_pkg.sv
package dpi_de_pkg;

  function automatic logic in_span(int unsigned pos, int unsigned first, int unsigned len);
    return (pos >= first) && (pos < first + len);
  endfunction

endpackage

// File: rtl/dpi_h_track.sv
module dpi_h_track #(
  parameter int unsigned LINE_LEN = 1650,
  parameter int unsigned XW       = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  output logic          rise_o,
  output logic          len_bad_o,
  output logic [XW-1:0] x_o
);
  localparam logic [XW-1:0] LenW = XW'(LINE_LEN);

  logic          hs_q, seen_q;
  logic [XW-1:0] cnt_q;

  assign rise_o = hsync_i & ~hs_q;
  assign x_o    = rise_o ? '0 : cnt_q;
  // short line at a rising edge, or overrun with no edge yet
  assign len_bad_o = seen_q & (rise_o ? (cnt_q != LenW) : (cnt_q == LenW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hs_q <= hsync_i;
      if (rise_o) seen_q <= 1'b1;
      cnt_q <= (&x_o) ? x_o : x_o + 1'b1;
    end
  end

endmodule

// File: rtl/dpi_v_track.sv
module dpi_v_track #(
  parameter int unsigned FRAME_LEN = 750,
  parameter int unsigned YW        = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vsync_i,
  input  logic          rise_h_i,
  output logic          bound_o,
  output logic          seen_o,
  output logic          cnt_bad_o,
  output logic [YW-1:0] y_o
);
  localparam logic [YW-1:0] LastW = YW'(FRAME_LEN - 1);

  logic          vs_q, pend_q, seen_q;
  logic [YW-1:0] cnt_q;
  logic          start;

  // a vsync edge opens the frame at the same or next hsync edge
  assign start   = (vsync_i & ~vs_q) | pend_q;
  assign bound_o = rise_h_i & start;
  assign seen_o  = seen_q;
  assign y_o     = bound_o  ? '0 :
                   rise_h_i ? ((&cnt_q) ? cnt_q : cnt_q + 1'b1) : cnt_q;
  assign cnt_bad_o = seen_q & rise_h_i & (start ? (cnt_q != LastW) : (cnt_q == LastW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= 1'b0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      vs_q   <= vsync_i;
      pend_q <= rise_h_i ? 1'b0 : start;
      seen_q <= seen_q | bound_o;
      cnt_q  <= y_o;
    end
  end

endmodule

// File: rtl/dpi_lock_track.sv
module dpi_lock_track #(
  parameter int unsigned NEED = 2,
  parameter int unsigned GW   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bound_i,
  input  logic seen_i,
  input  logic bad_i,
  output logic lock_o
);
  logic [GW-1:0] good_q, good_inc;
  logic          dirty_q, lock_q;

  assign good_inc = (&good_q) ? good_q : good_q + 1'b1;
  assign lock_o   = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q  <= '0;
      dirty_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (bound_i) begin
      dirty_q <= 1'b0;
      // a fault on the boundary sample belongs to the closing frame
      if (seen_i && !dirty_q && !bad_i) begin
        good_q <= good_inc;
        lock_q <= (32'(good_inc) >= NEED);
      end else begin
        good_q <= '0;
        lock_q <= 1'b0;
      end
    end else if (bad_i) begin
      dirty_q <= 1'b1;
      good_q  <= '0;
      lock_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/dpi_de_recover.sv
module dpi_de_recover
  import dpi_de_pkg::*;
#(
  parameter int unsigned H_ACTIVE    = 1280,
  parameter int unsigned H_FRONT     = 110,
  parameter int unsigned H_SYNC      = 40,
  parameter int unsigned H_BACK      = 220,
  parameter int unsigned V_ACTIVE    = 720,
  parameter int unsigned V_FRONT     = 5,
  parameter int unsigned V_SYNC      = 5,
  parameter int unsigned V_BACK      = 20,
  parameter int unsigned LOCK_FRAMES = 2,
  parameter int unsigned CW          = 8,
  localparam int unsigned H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
  localparam int unsigned V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT,
  localparam int unsigned XW      = $clog2(H_TOTAL + 2),
  localparam int unsigned YW      = $clog2(V_TOTAL + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic [CW-1:0] red_i,
  input  logic [CW-1:0] green_i,
  input  logic [CW-1:0] blue_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [CW-1:0] red_o,
  output logic [CW-1:0] green_o,
  output logic [CW-1:0] blue_o,
  output logic          de_o,
  output logic          lock_o,
  output logic [XW-1:0] px_x_o,
  output logic [YW-1:0] px_y_o
);
  localparam int unsigned GW = $clog2(LOCK_FRAMES + 1);

  logic          rise_h, h_bad, bound, v_seen, v_bad, mismatch, locked, in_win;
  logic [XW-1:0] x_w;
  logic [YW-1:0] y_w;

  dpi_h_track #(.LINE_LEN(H_TOTAL), .XW(XW)) i_h_track (
    .clk_i, .rst_ni, .hsync_i,
    .rise_o(rise_h), .len_bad_o(h_bad), .x_o(x_w)
  );

  dpi_v_track #(.FRAME_LEN(V_TOTAL), .YW(YW)) i_v_track (
    .clk_i, .rst_ni, .vsync_i, .rise_h_i(rise_h),
    .bound_o(bound), .seen_o(v_seen), .cnt_bad_o(v_bad), .y_o(y_w)
  );

  assign mismatch = h_bad | v_bad;

  dpi_lock_track #(.NEED(LOCK_FRAMES), .GW(GW)) i_lock_track (
    .clk_i, .rst_ni, .bound_i(bound), .seen_i(v_seen), .bad_i(mismatch),
    .lock_o(locked)
  );

  assign in_win = in_span(32'(x_w), H_SYNC + H_BACK, H_ACTIVE) &
                  in_span(32'(y_w), V_SYNC + V_BACK, V_ACTIVE);
  assign lock_o = locked;

  // single output stage keeps sync, colour and enable aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      red_o   <= '0;
      green_o <= '0;
      blue_o  <= '0;
      de_o    <= 1'b0;
      px_x_o  <= '0;
      px_y_o  <= '0;
    end else begin
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
      red_o   <= red_i;
      green_o <= green_i;
      blue_o  <= blue_i;
      de_o    <= locked & ~mismatch & in_win;
      px_x_o  <= x_w;
      px_y_o  <= y_w;
    end
  end

endmodule

// File: rtl/dpi_de_recover_chk.sv
module dpi_de_recover_chk #(
  parameter int unsigned H_ACTIVE = 1280,
  parameter int unsigned H_FRONT  = 110,
  parameter int unsigned H_SYNC   = 40,
  parameter int unsigned H_BACK   = 220,
  parameter int unsigned V_ACTIVE = 720,
  parameter int unsigned V_FRONT  = 5,
  parameter int unsigned V_SYNC   = 5,
  parameter int unsigned V_BACK   = 20,
  parameter int unsigned CW       = 8,
  localparam int unsigned H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
  localparam int unsigned V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT,
  localparam int unsigned XW      = $clog2(H_TOTAL + 2),
  localparam int unsigned YW      = $clog2(V_TOTAL + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_i,
  input logic          vsync_i,
  input logic [CW-1:0] red_i,
  input logic [CW-1:0] green_i,
  input logic [CW-1:0] blue_i,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [CW-1:0] red_o,
  input logic [CW-1:0] green_o,
  input logic [CW-1:0] blue_o,
  input logic          de_o,
  input logic          lock_o,
  input logic [XW-1:0] px_x_o,
  input logic [YW-1:0] px_y_o
);
  localparam logic [XW-1:0] XFirst = XW'(H_SYNC + H_BACK);
  localparam logic [XW-1:0] XLast  = XW'(H_SYNC + H_BACK + H_ACTIVE - 1);
  localparam logic [YW-1:0] YFirst = YW'(V_SYNC + V_BACK);
  localparam logic [YW-1:0] YEnd   = YW'(V_SYNC + V_BACK + V_ACTIVE);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_sync_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (hsync_o == $past(hsync_i)) && (vsync_o == $past(vsync_i)));

  p_rgb_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> {red_o, green_o, blue_o} == $past({red_i, green_i, blue_i}));

  p_de_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> px_x_o == XFirst);

  p_de_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(de_o) && lock_o) |-> $past(px_x_o) == XLast);

  p_de_rows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (px_y_o >= YFirst) && (px_y_o < YEnd));

  p_de_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && de_o) |-> $past(lock_o));

  p_lock_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (px_x_o == '0) && (px_y_o == '0));

endmodule

bind dpi_de_recover dpi_de_recover_chk #(
  .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
  .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
  .CW(CW)
) i_dpi_de_recover_chk (.*);

// File: tb/test_dpi_de_recover.sv
`timescale 1ns/1ps
module test_dpi_de_recover;
  localparam int HS = 2, HBP = 3, HACT = 8, HFP = 2;
  localparam int VS = 1, VBP = 2, VACT = 4, VFP = 1;
  localparam int HT = HS + HBP + HACT + HFP;
  localparam int VT = VS + VBP + VACT + VFP;
  localparam int XW = $clog2(HT + 2);
  localparam int YW = $clog2(VT + 2);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hsync_i = 1'b0, vsync_i = 1'b0;
  logic [7:0]    red_i = '0, green_i = '0, blue_i = '0;
  logic          hsync_o, vsync_o, de_o, lock_o;
  logic [7:0]    red_o, green_o, blue_o;
  logic [XW-1:0] px_x_o;
  logic [YW-1:0] px_y_o;

  dpi_de_recover #(
    .H_ACTIVE(HACT), .H_FRONT(HFP), .H_SYNC(HS), .H_BACK(HBP),
    .V_ACTIVE(VACT), .V_FRONT(VFP), .V_SYNC(VS), .V_BACK(VBP),
    .LOCK_FRAMES(2), .CW(8)
  ) i_dpi_de_recover (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit p_valid = 0, p_hs, p_vs, p_de, p_lk, p_lkb, lk_now = 0;
  logic [23:0] p_rgb;
  int p_x, p_y;
  string p_tag;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(int x, int y);
    return x >= HS + HBP && x < HS + HBP + HACT && y >= VS + VBP && y < VS + VBP + VACT;
  endfunction

  task automatic check_prev();
    check(hsync_o == p_hs && vsync_o == p_vs, "R2 sync", int'({vsync_o, hsync_o}), int'({p_vs, p_hs}));
    check({red_o, green_o, blue_o} == p_rgb, "R2 rgb", int'({red_o, green_o, blue_o}), int'(p_rgb));
    check(de_o == p_de, "R4 de", int'(de_o), int'(p_de));
    check(lock_o == p_lk, p_tag, int'(lock_o), int'(p_lk));
    if (p_lkb) begin
      check(int'(px_x_o) == p_x, "R3 x", int'(px_x_o), p_x);
      check(int'(px_y_o) == p_y, "R3 y", int'(px_y_o), p_y);
    end
  endtask

  // checks the previous sample, then drives position (x,y)
  task automatic send(int x, int y, bit lk_after, string tag);
    @(negedge clk_i);
    if (p_valid) check_prev();
    hsync_i = (x < HS);
    vsync_i = (y < VS);
    red_i   = 8'(x * 5 + y);
    green_i = 8'(y * 3 + 17);
    blue_i  = 8'(x ^ (y << 2));
    p_hs = hsync_i; p_vs = vsync_i; p_rgb = {red_i, green_i, blue_i};
    p_x = x; p_y = y; p_lkb = lk_now;
    p_de = lk_now & win(x, y);
    p_lk = lk_after; lk_now = lk_after;
    p_tag = tag; p_valid = 1;
  endtask

  task automatic flush();
    @(negedge clk_i);
    if (p_valid) check_prev();
    p_valid = 0;
  endtask

  task automatic do_reset();
    if (p_valid) flush();
    @(negedge clk_i);
    rst_ni = 1'b0;
    hsync_i = 0; vsync_i = 0; red_i = 0; green_i = 0; blue_i = 0;
    repeat (2) @(negedge clk_i);
    check(de_o == 0, "R1 de", int'(de_o), 0);
    check(lock_o == 0, "R1 lock", int'(lock_o), 0);
    check(hsync_o == 0 && vsync_o == 0, "R1 sync", int'({vsync_o, hsync_o}), 0);
    check({red_o, green_o, blue_o} == 0, "R1 rgb", int'({red_o, green_o, blue_o}), 0);
    check(px_x_o == 0 && px_y_o == 0, "R1 coord", int'(px_x_o) + int'(px_y_o), 0);
    rst_ni = 1'b1;
    p_valid = 0; lk_now = 0;
  endtask

  // one frame; line odd_line (if >=0) gets length odd_len
  task automatic frame(int nlines, int odd_line, int odd_len, bit lk_start, string tag);
    bit cur = lk_start;
    bit prev_short = 0;
    for (int l = 0; l < nlines; l++) begin
      int len = (l == odd_line) ? odd_len : HT;
      for (int x = 0; x < len; x++) begin
        if (l == 0 && x == 0) cur = lk_start;
        else if (x == 0 && prev_short) cur = 0;
        if (x == HT) cur = 0;
        send(x, l, cur, tag);
      end
      prev_short = (len < HT);
    end
  endtask

  task automatic t_acquire();
    frame(VT, -1, 0, 0, "R5 lock");
    frame(VT, -1, 0, 0, "R5 lock");
    frame(VT, -1, 0, 1, "R5 lock");
    frame(VT, -1, 0, 1, "R5 lock");
  endtask

  task automatic t_recover(string tag);
    frame(VT, -1, 0, 0, tag);
    frame(VT, -1, 0, 0, tag);
    frame(VT, -1, 0, 1, tag);
  endtask

  task automatic t_short_line();
    frame(VT, 3, HT - 3, 1, "R6 lock");
    t_recover("R9 lock");
  endtask

  task automatic t_long_line();
    frame(VT, 3, HT + 2, 1, "R7 lock");
    t_recover("R9 lock");
  endtask

  task automatic t_short_frame();
    frame(VT - 1, -1, 0, 1, "R8 lock");
    frame(VT, -1, 0, 0, "R8 lock");
    frame(VT, -1, 0, 0, "R9 lock");
    frame(VT, -1, 0, 1, "R9 lock");
  endtask

  task automatic t_reset_midrun();
    do_reset();
    frame(VT, -1, 0, 0, "R1 relock");
    frame(VT, -1, 0, 0, "R5 lock");
    frame(VT, -1, 0, 1, "R5 lock");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    do_reset();
    t_acquire();
    t_short_line();
    t_long_line();
    t_short_frame();
    t_reset_midrun();
    flush();
    report();
    $finish;
  end

endmodule